// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-master side of a processor-style system bus whose address and data share one set of wires. Each accepted request (address, direction, memory-or-I/O select and, for stores, write data) becomes exactly one bus cycle made of four clock states: T1, T2, T3 and T4. In T1 the address goes onto the shared bus and a one-clock latch strobe lets external logic capture it. From T2 the bus either carries write data or is released so a slave can drive read data, and the active-low read or write strobe is asserted together with a data-enable.

A slow slave holds the ready input low to stretch the cycle. Ready is sampled at the end of T2 and at the end of every wait state. Each low sample adds one whole wait state between T2 and T3. Read data is captured at the end of T3 and is presented with a one-clock done pulse in T4. In T4 all strobes are removed, so a write completes on the rising edge of the write strobe. When nothing is pending the sequencer sits in single-clock idle states. A request offered in T4 starts the next cycle with no idle state between.

Top module: `mux_bus_sequencer`

## Requirements
- R1: Every cycle runs T1, T2, N wait states, T3 and T4, so it lasts 4 + N clocks from the latch strobe to the end of the done clock.
- R2: In T1 the latch strobe `ale` is high for exactly one clock, `bus_oe` is high and `bus_out` carries the zero-extended address. `m_io` (1 = memory, 0 = I/O) and `dt_r` (1 = write, 0 = read) show the request's type and stay unchanged from T1 through T4.
- R3: From T2 through T3, including wait states, `den` is high and exactly one strobe is low: `rd_n` for a read, `wr_n` for a write. The two strobes are never low together.
- R4: In a write, `bus_oe` stays high and `bus_out` carries the zero-extended write data from T2 through T4. `wr_n` rises at the start of T4, which is the commit point.
- R5: In a read, `bus_oe` is low from T2 onward. `bus_in` is captured at the end of T3, and the captured value is on `rdata` while `done` is high.
- R6: `ready_in` is sampled at the end of T2 and at the end of each wait state. Each low sample inserts exactly one wait state, and T3 follows the first high sample.
- R7: In T4, `ale`, `den`, `rd_n` and `wr_n` are all inactive and `done` is high for exactly one clock.
- R8: `req_take` is high only in idle and in T4. A request is accepted at a clock edge where `req_valid` and `req_take` are both high, and `ale` rises in the next clock. A request raised in mid-cycle waits, and it starts with no idle clock after T4.
- R9: While idle, `ale` and `den` are low, `rd_n` and `wr_n` are high, `bus_oe` and `done` are low, and each idle state lasts one clock.
- R10: When `rst_n` goes low, the sequencer goes to idle at once, even in mid-cycle, with the outputs at their idle values. It leaves reset two clocks after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised on release |
| req_valid | input | 1 | A transfer request is offered |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wdata | input | DATA_W | Write data |
| req_take | output | 1 | Sequencer can accept a request at the next edge |
| ready_in | input | 1 | Slave ready, low inserts wait states |
| ale | output | 1 | Address latch strobe, high in T1 |
| dt_r | output | 1 | Data direction, 1 = transmit (write) |
| m_io | output | 1 | Space select, 1 = memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den | output | 1 | Data-enable for bus transceivers |
| bus_out | output | max(ADDR_W,DATA_W) | Multiplexed bus drive value |
| bus_oe | output | 1 | Multiplexed bus drive enable |
| bus_in | input | DATA_W | Multiplexed bus receive value (data lanes) |
| rdata | output | DATA_W | Captured read data |
| done | output | 1 | One-clock cycle-complete pulse in T4 |

## Verification
The embedded properties watch local rules on every clock. The two strobes never overlap, and a strobe never appears without the data-enable. The latch strobe and the done pulse each last one clock. The bus is released whenever the read strobe is low, the type outputs hold steady while data moves, and an accepted request is always followed by the latch strobe. Other behaviour can only be shown by the scenarios: the exact 4 + N cycle length under a chosen number of wait states, write data reaching a modelled slave on the trailing strobe edge and coming back on a later read, back-to-back cycles with no idle state, and an abort by reset in the middle of a wait state.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } bstate_t;

  function automatic logic in_data_phase(input bstate_t s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction
endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    ready_in,
  output bstate_t state,
  output logic    req_take,
  output logic    fire,
  output logic    done
);
  bstate_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid) state_nx = ST_T1;
      ST_T1:   state_nx = ST_T2;
      ST_T2:   state_nx = ready_in ? ST_T3 : ST_TW;
      ST_TW:   state_nx = ready_in ? ST_T3 : ST_TW;
      ST_T3:   state_nx = ST_T4;
      ST_T4:   state_nx = req_valid ? ST_T1 : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign req_take = (state == ST_IDLE) || (state == ST_T4);
  assign fire     = req_take && req_valid;
  assign done     = (state == ST_T4);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/busseq_strobes.sv
module busseq_strobes
  import busseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bstate_t state,
  input  logic    op_write,
  output logic    ale,
  output logic    den,
  output logic    rd_n,
  output logic    wr_n
);
  logic act;

  assign act  = in_data_phase(state);
  assign ale  = (state == ST_T1);
  assign den  = act;
  assign rd_n = !(act && !op_write);
  assign wr_n = !(act && op_write);

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_strobe_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> den);
endmodule

// File: rtl/busseq_datapath.sv
module busseq_datapath
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bstate_t           state,
  input  logic              fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              op_write,
  output logic              op_mem,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [BUS_W-1:0]  addr_ext, data_ext;
  logic              wdata_phase, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr  <= '0;
      op_write <= 1'b0;
      op_mem   <= 1'b0;
      op_wdata <= '0;
    end else if (fire) begin
      op_addr  <= req_addr;
      op_write <= req_write;
      op_mem   <= req_mem;
      op_wdata <= req_wdata;
    end
  end

  assign cap_en = (state == ST_T3) && !op_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= bus_in;
  end

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = op_addr;
    data_ext = '0;
    data_ext[DATA_W-1:0] = op_wdata;
  end

  assign wdata_phase = op_write && (in_data_phase(state) || state == ST_T4);

  always_comb begin
    if (state == ST_T1)   bus_out = addr_ext;
    else if (wdata_phase) bus_out = data_ext;
    else                  bus_out = '0;
  end

  assign bus_oe = (state == ST_T1) || wdata_phase;
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_take,
  input  logic              ready_in,
  output logic              ale,
  output logic              dt_r,
  output logic              m_io,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic    rst_meta_n, rst_q_n;
  bstate_t state;
  logic    fire, op_write, op_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  busseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n), .req_valid(req_valid), .ready_in(ready_in),
    .state(state), .req_take(req_take), .fire(fire), .done(done)
  );

  busseq_strobes u_strobes (
    .clk(clk), .rst_n(rst_q_n), .state(state), .op_write(op_write),
    .ale(ale), .den(den), .rd_n(rd_n), .wr_n(wr_n)
  );

  busseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_q_n), .state(state), .fire(fire),
    .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
    .req_wdata(req_wdata), .bus_in(bus_in), .op_write(op_write),
    .op_mem(op_mem), .bus_out(bus_out), .bus_oe(bus_oe), .rdata(rdata)
  );

  assign dt_r = op_write;
  assign m_io = op_mem;

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(!rd_n && !wr_n));
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_n |-> !bus_oe);
  p_den_fall_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(den) |-> done);
  p_take_ale_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_take) |=> ale);
  p_op_stable_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    den |-> ($stable(m_io) && $stable(dt_r)));
endmodule

// File: tb/test_mux_bus_sequencer.sv
module test_mux_bus_sequencer;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct {
    bit          wr;
    bit          mem;
    logic [19:0] addr;
    logic [15:0] data;
    int          waits;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, ready_in = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_take, ale, dt_r, m_io, rd_n, wr_n, den, bus_oe, done;
  logic [AW-1:0] bus_out;
  logic [DW-1:0] bus_in, rdata;

  always #5 clk = ~clk;

  mux_bus_sequencer #(.ADDR_W(AW), .DATA_W(DW)) i_mux_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mem(req_mem), .req_wdata(req_wdata),
    .req_take(req_take), .ready_in(ready_in), .ale(ale), .dt_r(dt_r),
    .m_io(m_io), .rd_n(rd_n), .wr_n(wr_n), .den(den), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in), .rdata(rdata), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  item_t cyc_q[$];
  int wait_q[$];
  logic [15:0] ref_mem [16];
  logic [15:0] slv_mem [16];
  logic [3:0]  lat = '0;
  logic        wr_prev = 1'b1;
  int          wl = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // slave model: address latch, write commit on trailing strobe edge
  assign bus_in = !rd_n ? slv_mem[lat] : 16'hDEAD;
  always @(negedge clk) begin
    if (ale) lat = bus_out[3:0];
    if (!wr_prev && wr_n) slv_mem[lat] = bus_out[15:0];
    wr_prev = wr_n;
  end

  // ready generator: N low samples per cycle
  always @(negedge clk) begin
    if (ale) begin
      wl = (wait_q.size() > 0) ? wait_q.pop_front() : 0;
    end else begin
      ready_in = (wl == 0);
      if (wl > 0) wl--;
    end
  end

  // monitor / scoreboard
  item_t cur;
  bit    in_cyc = 0;
  bit    prev_done = 0;
  int    ph = 0;
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      in_cyc = 0; prev_done = 0;
    end else begin
      if (prev_done) chk(!done, "R7", "done longer than one clock", done, 0);
      if (ale) begin
        if (cyc_q.size() == 0) chk(0, "R8", "ale without accepted request", 1, 0);
        else cur = cyc_q.pop_front();
        in_cyc = 1; ph = 0;
        chk(bus_oe && bus_out == cur.addr, "R2", "address phase bus_out",
            {11'b0, bus_oe, bus_out}, {12'h001, cur.addr});
        chk(m_io == cur.mem && dt_r == cur.wr, "R2", "m_io/dt_r in T1",
            {m_io, dt_r}, {cur.mem, cur.wr});
        chk(rd_n && wr_n && !den, "R2", "strobes idle in T1", {rd_n, wr_n, den}, 3'b110);
      end else if (in_cyc) begin
        ph++;
        chk(m_io == cur.mem && dt_r == cur.wr, "R2", "type held", {m_io, dt_r},
            {cur.mem, cur.wr});
        chk(!req_take || done, "R8", "req_take mid-cycle", req_take, 0);
        if (!done) begin
          if (cur.wr)
            chk(den && !wr_n && rd_n && bus_oe && bus_out == {4'h0, cur.data}, "R3",
                "write data phase", {den, wr_n, rd_n, bus_oe, bus_out[15:0]},
                {4'b1011, cur.data});
          else
            chk(den && !rd_n && wr_n && !bus_oe, "R5", "read data phase release",
                {den, rd_n, wr_n, bus_oe}, 4'b1010);
        end else begin
          chk(ph == 3 + cur.waits, "R1", "cycle length", ph + 1, 4 + cur.waits);
          chk(!ale && !den && rd_n && wr_n, "R7", "strobes off in T4",
              {ale, den, rd_n, wr_n}, 4'b0011);
          if (cur.wr)
            chk(bus_oe && bus_out[15:0] == cur.data, "R4", "write data held in T4",
                {bus_oe, bus_out[15:0]}, {1'b1, cur.data});
          else
            chk(rdata == cur.data, "R5", "captured read data", rdata, cur.data);
          in_cyc = 0;
        end
        if (ph > 3 + cur.waits) begin
          chk(0, "R6", "cycle overran its wait count", ph, 3 + cur.waits);
          in_cyc = 0;
        end
      end
      prev_done = done;
    end
  end

  task automatic do_xfer(input bit wr, input bit mem, input logic [19:0] a,
                         input logic [15:0] d, input int w);
    item_t it;
    it.wr = wr; it.mem = mem; it.addr = a; it.waits = w;
    it.data = wr ? d : ref_mem[a[3:0]];
    if (wr) ref_mem[a[3:0]] = d;
    req_valid = 1'b1; req_write = wr; req_mem = mem; req_addr = a; req_wdata = d;
    wait_q.push_back(w);
    cyc_q.push_back(it);
    while (!req_take) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk(ale, "R8", "ale one clock after acceptance", ale, 1);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!in_cyc) begin
        #1 chk(!ale && !den && rd_n && wr_n && !bus_oe && !done && req_take, "R9",
               "idle outputs", {ale, den, rd_n, wr_n, bus_oe, done, req_take},
               7'b0011001);
      end
    end
  endtask

  task automatic wait_quiet();
    while (in_cyc || cyc_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WDG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ref_mem[i] = 16'h1000 + 16'(i * 16'h0111);
      slv_mem[i] = ref_mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(!ale && !den && rd_n && wr_n && !bus_oe && !done && req_take, "R10",
           "reset state", {ale, den, rd_n, wr_n, bus_oe, done, req_take}, 7'b0011001);
    @(negedge clk);

    do_xfer(1, 1, 20'h00003, 16'hA5A5, 0);
    wait_quiet();
    idle_cycles(3);
    do_xfer(0, 1, 20'h00003, 16'h0000, 0);
    wait_quiet();
    idle_cycles(1);
    // back-to-back with waits (R6, R8)
    do_xfer(1, 0, 20'h00007, 16'h5A0F, 2);
    do_xfer(0, 0, 20'h00007, 16'h0000, 1);
    do_xfer(0, 1, 20'h0000A, 16'h0000, 3);
    do_xfer(1, 1, 20'hFFFF5, 16'hC3E1, 0);
    do_xfer(0, 1, 20'hABCD5, 16'h0000, 4);
    wait_quiet();
    idle_cycles(2);
    for (int i = 0; i < 8; i++) begin
      do_xfer(1, i[0], 20'(i * 20'h11111), 16'(16'h2200 + i * 7), i % 4);
      do_xfer(0, i[0], 20'(i * 20'h11111), 16'h0000, (i + 1) % 3);
    end
    wait_quiet();
    idle_cycles(2);

    // reset in the middle of a wait state (R10)
    do_xfer(0, 1, 20'h00002, 16'h0000, 5);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk(!ale && !den && rd_n && wr_n && !bus_oe && !done, "R10",
           "abort to idle mid-cycle", {ale, den, rd_n, wr_n, bus_oe, done}, 6'b001100);
    cyc_q.delete(); wait_q.delete(); wl = 0; ready_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(!den && rd_n && wr_n && req_take, "R10", "idle after reset release",
           {den, rd_n, wr_n, req_take}, 4'b0111);
    @(negedge clk);
    do_xfer(0, 0, 20'h00003, 16'h0000, 1);
    wait_quiet();
    idle_cycles(2);
    finish_run();
  end
endmodule